// File: doc/BRIEF.md
# Dual Non-Overlapping PWM Generator

This block drives two PWM outputs from one clock. The primary output is high for a programmed number of clocks at the start of each period. The secondary output fills the primary's low phase, with a programmable guard interval at each of its edges, so the two outputs are never high at the same time. All settings are written over an 8-bit write port. Each 16-bit quantity is split into a low byte and a high byte. The low byte waits in a holding register and the whole value becomes the new target only when the high byte arrives.

The period is programmed as the wanted period minus two clocks. In immediate mode, new targets are adopted at the next period boundary. In slewing mode, the active period and duty move one count per step toward their targets. A step is taken once every (step delay + 1) period boundaries. A frame-length register is kept and exposed for an external locking loop. Clearing the enable holds both outputs low and parks the cycle counter at zero.

Top module: `dual_pwm`

## Requirements
- R1: The write port decodes these addresses: 0 control, 1/2 period low/high, 3/4 duty low/high, 5/6 guard low/high, 7 step delay, 8/9 frame length low/high. Every register resets to zero. A low-byte write alone changes nothing. The 16-bit value {high, held low} takes effect when the high byte is written.
- R2: With period setting N, the primary output repeats every N+2 clocks.
- R3: The primary output is high for the first D clocks of each period, where D is the duty setting. It stays low when D = 0 and stays high when D is greater than or equal to N+2.
- R4: The secondary output rises G clocks after the primary falls, where G is the guard setting, and falls G clocks before the next period starts. Its high time is max(0, N+2-D-2G) clocks, and it never overlaps the primary.
- R5: In immediate mode (control bit 1 = 0), a new period or duty is adopted only at a period boundary. Every observed period is therefore either the old length or the new length.
- R6: In slewing mode (control bit 1 = 1), the active period and duty each move by one count toward their targets. A step happens only at every (S+1)-th period boundary, where S is the step-delay setting. Each intermediate period length therefore lasts exactly S+1 periods.
- R7: Control bit 0 is the enable. While it is 0, both outputs are low and the counter is held at zero. After it is set, the primary output rises on the second clock edge (when D > 0).
- R8: The 16-bit frame length is presented on `frame_len`. It follows the same low/high write rule as R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that counts all periods |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Write data byte |
| pwm_a | output | 1 | Primary PWM output (registered) |
| pwm_b | output | 1 | Secondary, non-overlapping PWM output (registered) |
| frame_len | output | 16 | Stored frame-length value |

## Verification
On every cycle, the assertions check four things: the two outputs never overlap, a cleared enable forces both outputs low, the counter stays within the active period, and the active period changes only at a boundary. In slewing mode they also check that the active period changes by no more than one count at a time. The exact high time, guard interval and period length for each setting can only be shown by the bench's measured windows. The same holds for the count of boundaries between slew steps and for the no-effect behaviour of a lone low-byte write.

// File: rtl/dual_pwm.sv
module dual_pwm (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [7:0]  wr_data,
  output logic        pwm_a,
  output logic        pwm_b,
  output logic [15:0] frame_len
);

  logic        en, smooth;
  logic [7:0]  step_dly, skip;
  logic [7:0]  lo_per, lo_duty, lo_gap, lo_frm;
  logic [15:0] tgt_per, tgt_duty, gap;
  logic [15:0] act_per, act_duty, cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; smooth <= 1'b0; step_dly <= '0;
      lo_per <= '0; lo_duty <= '0; lo_gap <= '0; lo_frm <= '0;
      tgt_per <= '0; tgt_duty <= '0; gap <= '0; frame_len <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        4'd0: {smooth, en} <= wr_data[1:0];
        4'd1: lo_per <= wr_data;
        4'd2: tgt_per <= {wr_data, lo_per};
        4'd3: lo_duty <= wr_data;
        4'd4: tgt_duty <= {wr_data, lo_duty};
        4'd5: lo_gap <= wr_data;
        4'd6: gap <= {wr_data, lo_gap};
        4'd7: step_dly <= wr_data;
        4'd8: lo_frm <= wr_data;
        4'd9: frame_len <= {wr_data, lo_frm};
        default: ;
      endcase
    end
  end

  function automatic logic [15:0] toward(input logic [15:0] cur, input logic [15:0] tgt);
    if (cur < tgt)      toward = cur + 16'd1;
    else if (cur > tgt) toward = cur - 16'd1;
    else                toward = cur;
  endfunction

  wire [16:0] plen   = {1'b0, act_per} + 17'd2;
  wire [16:0] cnt17  = {1'b0, cnt};
  wire        wrap   = cnt17 >= plen - 17'd1;
  wire        at_tgt = (act_per == tgt_per) && (act_duty == tgt_duty);
  wire        a_nxt  = cnt17 < {1'b0, act_duty};
  wire        b_nxt  = (cnt17 >= {1'b0, act_duty} + {1'b0, gap}) &&
                       (cnt17 + {1'b0, gap} < plen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; act_per <= '0; act_duty <= '0; skip <= '0;
    end else if (!en) begin
      cnt <= '0; act_per <= tgt_per; act_duty <= tgt_duty; skip <= '0;
    end else begin
      cnt <= wrap ? 16'd0 : cnt + 16'd1;
      if (wrap) begin
        if (!smooth) begin
          act_per <= tgt_per; act_duty <= tgt_duty; skip <= '0;
        end else if (at_tgt) begin
          skip <= '0;
        end else if (skip >= step_dly) begin
          act_per  <= toward(act_per, tgt_per);
          act_duty <= toward(act_duty, tgt_duty);
          skip <= '0;
        end else begin
          skip <= skip + 8'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_a <= 1'b0; pwm_b <= 1'b0;
    end else begin
      pwm_a <= en & a_nxt;
      pwm_b <= en & b_nxt;
    end
  end

endmodule

// File: rtl/dual_pwm_chk.sv
module dual_pwm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        smooth,
  input logic [15:0] cnt,
  input logic [15:0] act_per,
  input logic [15:0] act_duty,
  input logic        pwm_a,
  input logic        pwm_b
);

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwm_a && pwm_b));

  assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pwm_a && !pwm_b));

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt} <= {1'b0, act_per} + 17'd1);

  assert_zero_duty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_duty == 16'd0) |=> !pwm_a);

  assert_boundary_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && ({1'b0, $past(cnt)} != {1'b0, $past(act_per)} + 17'd1))
      |-> ($stable(act_per) && $stable(act_duty)));

  assert_unit_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && smooth && $past(smooth))
      |-> (act_per == $past(act_per) || act_per == $past(act_per) + 16'd1 ||
           act_per == $past(act_per) - 16'd1));

endmodule

bind dual_pwm dual_pwm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .smooth(smooth), .cnt(cnt),
  .act_per(act_per), .act_duty(act_duty), .pwm_a(pwm_a), .pwm_b(pwm_b)
);

// File: tb/dual_pwm_bench.sv
module dual_pwm_bench;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic pwm_a, pwm_b;
  logic [15:0] frame_len;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  dual_pwm u_dual_pwm (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b), .frame_len(frame_len));

  // period setting, duty, guard, expected a-high, b-high, dead time
  localparam int NV = 7;
  localparam int VEC [NV][6] = '{
    '{8, 3, 1, 3, 5, 1},
    '{18, 10, 2, 10, 6, 2},
    '{3, 1, 0, 1, 4, 0},
    '{30, 20, 5, 20, 2, 5},
    '{8, 4, 3, 4, 0, 0},
    '{0, 1, 0, 1, 1, 0},
    '{298, 256, 4, 256, 36, 4}
  };

  // period monitor: logs length between primary rises
  int plog [512];
  int nlog = 0, run = 0;
  logic a_prev = 1'b0;
  always @(negedge clk) begin
    if (pwm_a && !a_prev) begin
      plog[nlog % 512] = run; nlog = nlog + 1; run = 1;
    end else run = run + 1;
    a_prev = pwm_a;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a[3:0]; wr_data = d[7:0];
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic prog(input int per, input int duty, input int g, input int ctrl);
    wr(0, 0);
    wr(1, per & 255); wr(2, per >> 8);
    wr(3, duty & 255); wr(4, duty >> 8);
    wr(5, g & 255); wr(6, g >> 8);
    wr(0, ctrl);
  endtask

  task automatic measure(input int p, input int ha_e, input int hb_e, input int dead_e);
    int ha = 0, hb = 0, ov = 0, fb = -1, g = 0;
    logic prev, last_a;
    repeat (2 * p + 4) @(negedge clk);
    prev = pwm_a;
    do begin @(negedge clk); g++; if (pwm_a && !prev) break; prev = pwm_a; end while (g < 2000);
    for (int i = 0; i < p; i++) begin
      if (i > 0) @(negedge clk);
      ha += int'(pwm_a); hb += int'(pwm_b); ov += int'(pwm_a & pwm_b);
      if (pwm_b && fb < 0) fb = i;
      last_a = pwm_a;
    end
    @(negedge clk);
    chk(pwm_a && !last_a, "R2 period length", int'(pwm_a), 1);
    chk(ha == ha_e, "R3 primary high time", ha, ha_e);
    chk(hb == hb_e, "R4 secondary high time", hb, hb_e);
    chk(ov == 0, "R4 overlap count", ov, 0);
    if (hb_e > 0) chk(fb - ha == dead_e, "R4 dead time", fb - ha, dead_e);
  endtask

  task automatic check_slew(input int s, input int from, input int to, input int d);
    int cur, rl, step;
    step = (to > from) ? 1 : -1;
    cur = plog[s % 512]; rl = 1;
    chk(cur == from, "R6 slew start", cur, from);
    for (int k = s + 1; k < nlog; k++) begin
      int v = plog[k % 512];
      if (v == cur) rl++;
      else begin
        chk(v == cur + step, "R6 unit step", v, cur + step);
        if (cur != from) chk(rl == d + 1, "R6 periods per step", rl, d + 1);
        cur = v; rl = 1;
      end
    end
    chk(cur == to, "R6 slew end", cur, to);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int s, hi, ok;
    repeat (3) @(negedge clk);
    chk(!pwm_a && !pwm_b, "R1 reset outputs", int'(pwm_a | pwm_b), 0);
    chk(frame_len == 16'd0, "R1 reset frame_len", int'(frame_len), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!pwm_a && !pwm_b, "R7 idle after reset", int'(pwm_a | pwm_b), 0);

    for (int v = 0; v < NV; v++) begin
      prog(VEC[v][0], VEC[v][1], VEC[v][2], 1);
      measure(VEC[v][0] + 2, VEC[v][3], VEC[v][4], VEC[v][5]);
    end

    // R3 duty zero and duty at or above period
    prog(8, 0, 1, 1);
    hi = 0; for (int i = 0; i < 40; i++) begin @(negedge clk); hi += int'(pwm_a); end
    chk(hi == 0, "R3 duty zero", hi, 0);
    prog(8, 10, 1, 1);
    repeat (3) @(negedge clk);
    hi = 0; for (int i = 0; i < 40; i++) begin @(negedge clk); hi += int'(pwm_a) + 2 * int'(pwm_b); end
    chk(hi == 40, "R3 duty equals period", hi, 40);
    prog(8, 500, 1, 1);
    repeat (3) @(negedge clk);
    hi = 0; for (int i = 0; i < 40; i++) begin @(negedge clk); hi += int'(pwm_a) + 2 * int'(pwm_b); end
    chk(hi == 40, "R3 duty above period", hi, 40);

    // R7 enable
    prog(8, 3, 1, 1);
    repeat (25) @(negedge clk);
    wr(0, 0);
    hi = 0; for (int i = 0; i < 30; i++) begin @(negedge clk); hi += int'(pwm_a | pwm_b); end
    chk(hi == 0, "R7 disabled outputs low", hi, 0);
    wr(0, 1);
    chk(!pwm_a, "R7 first edge after enable", int'(pwm_a), 0);
    @(negedge clk);
    chk(pwm_a, "R7 rise on second edge", int'(pwm_a), 1);

    // R1 lone low byte, R5 boundary adoption
    repeat (30) @(negedge clk);
    wr(1, 18);
    repeat (40) @(negedge clk);
    @(posedge clk);
    chk(plog[(nlog - 1) % 512] == 10, "R1 low byte alone", plog[(nlog - 1) % 512], 10);
    s = nlog;
    wr(2, 0);
    repeat (150) @(negedge clk);
    @(posedge clk);
    ok = 1;
    for (int k = s; k < nlog; k++) if (plog[k % 512] != 10 && plog[k % 512] != 20) ok = 0;
    chk(ok == 1, "R5 no torn period", ok, 1);
    chk(plog[(nlog - 1) % 512] == 20, "R5 new period adopted", plog[(nlog - 1) % 512], 20);

    // R8 frame length
    wr(8, 8'h34);
    chk(frame_len == 16'd0, "R8 frame low byte held", int'(frame_len), 0);
    wr(9, 8'h12);
    chk(frame_len == 16'h1234, "R8 frame value", int'(frame_len), 16'h1234);

    // R6 slewing up with step delay 2
    wr(7, 2); wr(0, 3);
    repeat (25) @(negedge clk);
    @(posedge clk); s = nlog;
    wr(1, 22); wr(2, 0);
    repeat (400) @(negedge clk);
    @(posedge clk);
    check_slew(s, 20, 24, 2);

    // R6 slewing down with step delay 0
    wr(7, 0);
    @(posedge clk); s = nlog;
    wr(1, 18); wr(2, 0);
    repeat (200) @(negedge clk);
    @(posedge clk);
    check_slew(s, 24, 20, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule